// File: doc/BRIEF.md
# Error-Correcting Word Memory with Byte-Merge Writes

This block is a synchronous memory for 32-bit words. Each word is kept alongside seven extra bits: six Hamming check bits and one overall parity bit. On every read the block decodes the stored codeword. It repairs any single flipped bit and reports it. When two bits have flipped it raises an uncorrectable flag and makes no repair.

A client issues one request per cycle while `reqReady` is high.

- **Full-word write.** A write with all four byte enables set is encoded and stored at the clock edge that accepts it.
- **Partial write.** Any other byte-enable pattern starts an internal sequence and holds `reqReady` low for two cycles. The first busy cycle reads the old codeword. The second busy cycle (the write-back cycle) decodes and repairs that word, merges in the enabled bytes, re-encodes the result and stores it. If the old word cannot be corrected, the write is dropped.
- **Fault injection.** A test port flips chosen bits of a stored codeword, so that single and double faults can be created on purpose.

Top module: `ecc_mem_rmw`

## Requirements
- R1: While reset is applied and after it is released, `reqReady` is 1, and `rspValid`, `errCorrected` and `errUncorrectable` are 0. Every word reads back as zero with no flag raised.
- R2: An accepted read (`reqWrite`=0) raises `rspValid` in the next cycle only. `rspData` then equals the last word written to that address.
- R3: A write with `reqByteEn`=4'b1111 is stored at its acceptance edge, and `reqReady` stays 1 in the next cycle.
- R4: A write with any other `reqByteEn` value drops `reqReady` for exactly the two cycles after acceptance. Byte k means `reqWdata[8k+7:8k]`. Bytes whose enable is 0 keep their old value.
- R5: A single flipped stored bit is corrected on read, and `errCorrected` is 1 while `rspValid` is 1. This applies to any of the 39 stored bits: bit 0 is the overall parity, bit p (1..38) is codeword position p, and the check bits sit at positions 1, 2, 4, 8, 16 and 32.
- R6: When two stored bits have flipped, a read gives `errUncorrectable`=1 and `errCorrected`=0.
- R7: A partial write to a word with one flipped bit merges the new bytes into the corrected old data. It raises `errCorrected` in the write-back cycle and stores a clean codeword, so a later read shows no flag.
- R8: A partial write to a word with two flipped bits is aborted. `errUncorrectable` is 1 in the write-back cycle, and the stored codeword is left unchanged.
- R9: `errCorrected` and `errUncorrectable` are 0 in every cycle that is neither a response cycle nor a write-back cycle.
- R10: A request presented while `reqReady` is 0 is ignored and changes no stored word.
- R11: Injection XORs `injMask` into the stored codeword at `injAddr`. Injecting the same mask twice restores the word, and it then reads clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 4 | Word address |
| reqByteEn | input | 4 | Byte enables for writes |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | Block can accept a request this cycle |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Corrected read data |
| errCorrected | output | 1 | Single error repaired (response or write-back cycle) |
| errUncorrectable | output | 1 | Double error seen (response or write-back cycle) |
| injValid | input | 1 | Apply fault injection this cycle |
| injAddr | input | 4 | Word address for injection |
| injMask | input | 39 | Stored bits to flip |

## Verification
A sequencer that sticks or skips a state shows up on `reqReady` within one cycle of the partial write being accepted, because the busy window must last exactly two cycles. A syndrome or parity fault shows up in the response cycle of the read that follows an injection, as a wrong flag or wrong data. A bad merge or a bad re-encode during write-back only appears at the next read of that address. For that reason the bench reads every word it has touched and compares each cycle against a model that tracks both the data and the accumulated fault masks.

// File: rtl/ecc_mem_pkg.sv
`timescale 1ns/1ps
package ecc_mem_pkg;

  // Smallest number of Hamming check bits r such that 2^r >= dataW + r + 1
  function automatic int chkBitsFor(input int dataW);
    for (int r = 1; r < 31; r++) begin
      if ((1 << r) >= dataW + r + 1) return r;
    end
    return 31;
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WB   = 2'd2
  } seqState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic rdReq;      // array read at request address, respond next cycle
    logic wrFull;     // full-word write at request address
    logic latchReq;   // capture a partial write request
    logic rdLatched;  // array read at captured address
    logic wbLive;     // write-back cycle: decode, merge, store
  } ctrlStrobe_t;

endpackage

// File: rtl/ecc_mem_ctrl.sv
`timescale 1ns/1ps
module ecc_mem_ctrl
  import ecc_mem_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [BE_W-1:0] reqByteEn,
  output logic            reqReady,
  output ctrlStrobe_t     strb
);

  seqState_e state, stateNext;
  logic accept, fullWord;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign fullWord = &reqByteEn;

  always_comb begin
    strb           = '0;
    strb.rdReq     = accept && !reqWrite;
    strb.wrFull    = accept && reqWrite && fullWord;
    strb.latchReq  = accept && reqWrite && !fullWord;
    strb.rdLatched = (state == ST_RD);
    strb.wbLive    = (state == ST_WB);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strb.latchReq) stateNext = ST_RD;
      ST_RD:   stateNext = ST_WB;
      ST_WB:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/ecc_mem_dp.sv
`timescale 1ns/1ps
module ecc_mem_dp
  import ecc_mem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BE_W   = DATA_W / 8,
  localparam int CHK_W  = chkBitsFor(DATA_W),
  localparam int CW_W   = DATA_W + CHK_W,
  localparam int ST_W   = CW_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqByteEn,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              injValid,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [ST_W-1:0]   injMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              errCorrected,
  output logic              errUncorrectable
);

  localparam int SYN_W = $clog2(CW_W + 1);

  // Stored word: bit 0 = overall parity, bit p = Hamming position p
  function automatic logic [ST_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [ST_W-1:0] w;
    int k;
    w = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[p] = d[k];
        k++;
      end
    end
    for (int c = 0; c < CHK_W; c++) begin
      for (int p = 1; p <= CW_W; p++) begin
        if (((p >> c) & 1) == 1 && p != (1 << c)) w[1 << c] = w[1 << c] ^ w[p];
      end
    end
    w[0] = ^w[ST_W-1:1];
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] extract(input logic [ST_W-1:0] w);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = w[p];
        k++;
      end
    end
    return d;
  endfunction

  logic [ST_W-1:0]   mem [DEPTH];
  logic [ST_W-1:0]   rdWord, fixedWord, wbWord;
  logic [SYN_W-1:0]  syndrome;
  logic              parityBad, isSingle, isDouble, decodeLive;
  logic [DATA_W-1:0] corrData, mergedData;
  logic [ADDR_W-1:0] latAddr;
  logic [BE_W-1:0]   latBe;
  logic [DATA_W-1:0] latData;

  // Syndrome and overall parity
  always_comb begin
    syndrome = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (rdWord[p]) syndrome = syndrome ^ SYN_W'(p);
    end
    parityBad = ^rdWord;
    isSingle  = parityBad && (int'(syndrome) <= CW_W);
    isDouble  = (!parityBad && syndrome != '0) || (parityBad && int'(syndrome) > CW_W);
    fixedWord = rdWord;
    if (isSingle) fixedWord[syndrome] = ~rdWord[syndrome];
    corrData  = extract(fixedWord);
  end

  // Byte merge for the write-back
  for (genvar b = 0; b < BE_W; b++) begin : gMerge
    assign mergedData[8*b +: 8] = latBe[b] ? latData[8*b +: 8] : corrData[8*b +: 8];
  end

  assign wbWord     = encode(mergedData);
  assign decodeLive = rspValid || strb.wbLive;

  assign rspData          = corrData;
  assign errCorrected     = decodeLive && isSingle;
  assign errUncorrectable = decodeLive && isDouble;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdWord   <= '0;
      rspValid <= 1'b0;
      latAddr  <= '0;
      latBe    <= '0;
      latData  <= '0;
    end else begin
      rspValid <= strb.rdReq;
      if (strb.rdReq)          rdWord <= mem[reqAddr];
      else if (strb.rdLatched) rdWord <= mem[latAddr];
      if (strb.latchReq) begin
        latAddr <= reqAddr;
        latBe   <= reqByteEn;
        latData <= reqWdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.wrFull) begin
      mem[reqAddr] <= encode(reqWdata);
    end else if (strb.wbLive && !isDouble) begin
      mem[latAddr] <= wbWord;
    end else if (injValid) begin
      mem[injAddr] <= mem[injAddr] ^ injMask;
    end
  end

endmodule

// File: rtl/ecc_mem_rmw.sv
`timescale 1ns/1ps
module ecc_mem_rmw
  import ecc_mem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BE_W   = DATA_W / 8,
  localparam int ST_W   = DATA_W + chkBitsFor(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqByteEn,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              errCorrected,
  output logic              errUncorrectable,
  input  logic              injValid,
  input  logic [ADDR_W-1:0] injAddr,
  input  logic [ST_W-1:0]   injMask
);

  ctrlStrobe_t strb;

  ecc_mem_ctrl #(.BE_W(BE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqByteEn(reqByteEn), .reqReady(reqReady), .strb(strb)
  );

  ecc_mem_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqByteEn(reqByteEn), .reqWdata(reqWdata), .injValid(injValid),
    .injAddr(injAddr), .injMask(injMask), .rspValid(rspValid),
    .rspData(rspData), .errCorrected(errCorrected),
    .errUncorrectable(errUncorrectable)
  );

endmodule

// File: rtl/ecc_mem_chk.sv
`timescale 1ns/1ps
module ecc_mem_chk #(
  parameter int BE_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqWrite,
  input logic [BE_W-1:0] reqByteEn,
  input logic            reqReady,
  input logic            rspValid,
  input logic            errCorrected,
  input logic            errUncorrectable
);

  // R2
  read_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite) |=> rspValid);

  // R2
  resp_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady && !reqWrite));

  // R3
  full_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && (&reqByteEn)) |=> reqReady);

  // R4
  partial_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite && !(&reqByteEn)) |=> !reqReady);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && !$past(reqReady)) |=> reqReady);

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(errCorrected && errUncorrectable));

  // R9
  flag_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCorrected || errUncorrectable) |-> (rspValid || !reqReady));

endmodule

bind ecc_mem_rmw ecc_mem_chk #(.BE_W(DATA_W / 8)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqByteEn(reqByteEn), .reqReady(reqReady), .rspValid(rspValid),
  .errCorrected(errCorrected), .errUncorrectable(errUncorrectable)
);

// File: tb/sim_ecc_mem_rmw.sv
`timescale 1ns/1ps
module sim_ecc_mem_rmw;

  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int SW = 39;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [3:0] reqByteEn = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspValid, errCorrected, errUncorrectable;
  logic [DW-1:0] rspData;
  logic injValid = 1'b0;
  logic [AW-1:0] injAddr = '0;
  logic [SW-1:0] injMask = '0;

  always #2.5 clk = ~clk;

  ecc_mem_rmw u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqByteEn(reqByteEn), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData),
    .errCorrected(errCorrected), .errUncorrectable(errUncorrectable),
    .injValid(injValid), .injAddr(injAddr), .injMask(injMask)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "";

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [DW-1:0] mData [DEPTH];
  logic [SW-1:0] mMask [DEPTH];
  int busy = 0;
  logic [AW-1:0] pAddr;
  logic [3:0] pBe;
  logic [DW-1:0] pData;
  bit expRv = 0;
  logic [DW-1:0] expData;
  int expOnes = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        mData[i] = '0;
        mMask[i] = '0;
      end
      busy = 0;
      expRv = 0;
    end else begin
      expRv = 0;
      if (busy == 1) begin
        if ($countones(mMask[pAddr]) != 2) begin
          for (int k = 0; k < 4; k++) if (pBe[k]) mData[pAddr][8*k +: 8] = pData[8*k +: 8];
          mMask[pAddr] = '0;
        end
        busy = 0;
      end else if (busy == 2) begin
        busy = 1;
      end else if (reqValid) begin
        if (!reqWrite) begin
          expRv = 1;
          expData = mData[reqAddr];
          expOnes = $countones(mMask[reqAddr]);
        end else if (reqByteEn == 4'hF) begin
          mData[reqAddr] = reqWdata;
          mMask[reqAddr] = '0;
        end else begin
          busy = 2;
          pAddr = reqAddr;
          pBe = reqByteEn;
          pData = reqWdata;
        end
      end else if (injValid) begin
        mMask[injAddr] = mMask[injAddr] ^ injMask;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(reqReady === (busy == 0), "R4 ready", 64'(reqReady), 64'(busy == 0));
      if (expRv) begin
        chk(rspValid === 1'b1, "R2 rspValid", 64'(rspValid), 64'd1);
        if (expOnes < 2)
          chk(rspData === expData, (phase != "") ? phase : ((expOnes == 1) ? "R5 data" : "R2 data"),
              64'(rspData), 64'(expData));
        chk(errCorrected === (expOnes == 1), (expOnes == 1) ? "R5 corrected" : "R2 corrected",
            64'(errCorrected), 64'(expOnes == 1));
        chk(errUncorrectable === (expOnes == 2), "R6 uncorrectable",
            64'(errUncorrectable), 64'(expOnes == 2));
      end else if (busy == 1) begin
        chk(errCorrected === ($countones(mMask[pAddr]) == 1), "R7 wb corrected",
            64'(errCorrected), 64'($countones(mMask[pAddr]) == 1));
        chk(errUncorrectable === ($countones(mMask[pAddr]) == 2), "R8 wb uncorrectable",
            64'(errUncorrectable), 64'($countones(mMask[pAddr]) == 2));
        chk(rspValid === 1'b0, "R9 rspValid", 64'(rspValid), 64'd0);
      end else begin
        chk(rspValid === 1'b0, "R9 rspValid", 64'(rspValid), 64'd0);
        chk(errCorrected === 1'b0, "R9 corrected", 64'(errCorrected), 64'd0);
        chk(errUncorrectable === 1'b0, "R9 uncorrectable", 64'(errUncorrectable), 64'd0);
      end
    end
  end

  task automatic waitIdle();
    while (busy != 0) @(negedge clk);
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] d);
    waitIdle();
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqByteEn = be; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    issue(1'b0, a, 4'h0, '0);
    @(negedge clk);
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [SW-1:0] m);
    waitIdle();
    injValid = 1'b1; injAddr = a; injMask = m;
    @(negedge clk);
    injValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: values during reset
    chk(reqReady === 1'b1, "R1 ready in reset", 64'(reqReady), 64'd1);
    chk(rspValid === 1'b0, "R1 rspValid in reset", 64'(rspValid), 64'd0);
    chk(errCorrected === 1'b0 && errUncorrectable === 1'b0, "R1 flags in reset",
        64'({errCorrected, errUncorrectable}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    phase = "R1 zero after reset";
    for (int a = 0; a < DEPTH; a++) rd(AW'(a));

    // R3 and R2: full-word writes and read-back
    phase = "R2 full write";
    for (int a = 0; a < DEPTH; a++) begin
      issue(1'b1, AW'(a), 4'hF, 32'h1234_0000 ^ (32'h9E37_79B9 * (a + 1)));
      chk(reqReady === 1'b1, "R3 ready after full write", 64'(reqReady), 64'd1);
    end
    for (int a = 0; a < DEPTH; a++) rd(AW'(a));

    // R4: partial writes under several enable patterns
    phase = "R4 partial merge";
    issue(1'b1, 4'd1, 4'b0001, 32'hAAAA_AAAA);
    issue(1'b1, 4'd2, 4'b1010, 32'h5555_5555);
    issue(1'b1, 4'd3, 4'b0110, 32'hDEAD_BEEF);
    issue(1'b1, 4'd4, 4'b0000, 32'hFFFF_FFFF);
    issue(1'b1, 4'd4, 4'b1000, 32'h7700_0000);
    for (int a = 1; a <= 4; a++) rd(AW'(a));

    // R5 and R11: every single-bit fault, then cancelled by a second injection
    for (int b = 0; b < SW; b++) begin
      phase = "R5 single fix";
      inject(4'd7, SW'(1) << b);
      rd(4'd7);
      phase = "R11 cancel";
      inject(4'd7, SW'(1) << b);
      rd(4'd7);
    end

    // R6: double-bit faults
    phase = "R6 double";
    for (int b = 0; b < SW - 9; b += 5) begin
      inject(4'd8, (SW'(1) << b) | (SW'(1) << (b + 9)));
      rd(4'd8);
      inject(4'd8, (SW'(1) << b) | (SW'(1) << (b + 9)));
      rd(4'd8);
    end

    // R7: partial write over a single fault
    phase = "R7 rmw corrected";
    inject(4'd5, SW'(1) << 20);
    issue(1'b1, 4'd5, 4'b0010, 32'h0000_C300);
    rd(4'd5);
    inject(4'd9, SW'(1) << 16);
    issue(1'b1, 4'd9, 4'b1101, 32'h0102_0304);
    rd(4'd9);

    // R8: partial write over a double fault is aborted
    phase = "R8 rmw aborted";
    inject(4'd6, (SW'(1) << 3) | (SW'(1) << 30));
    issue(1'b1, 4'd6, 4'b0100, 32'h00EE_0000);
    rd(4'd6);
    inject(4'd6, (SW'(1) << 3) | (SW'(1) << 30));
    rd(4'd6);

    // R10: requests during busy cycles are ignored
    phase = "R10 ignored while busy";
    waitIdle();
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 4'd10; reqByteEn = 4'b0011; reqWdata = 32'h0000_1111;
    @(negedge clk);
    reqAddr = 4'd11; reqByteEn = 4'hF; reqWdata = 32'hBAD0_BAD0;
    @(negedge clk);
    reqAddr = 4'd12;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    rd(4'd11);
    rd(4'd12);
    rd(4'd10);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule